// File: doc/BRIEF.md
# NFC-F Frame Receiver Deframer

This block sits behind a 212/424 kbit/s NFC-F demodulator that hands over the received bit stream eight bits at a time. The bytes arrive without any alignment to frame boundaries. The block hunts for the 16-bit sync word at any bit position and locks onto that bit offset. After that, it repacks each later input byte across the offset so that every frame byte comes out whole. It then reads the length byte, the payload and a two-byte CRC.

Each recovered frame byte is presented for one cycle on a small output port, from the length byte through the last CRC byte. When the last CRC byte has been taken, the block pulses a completion strobe. It also latches the full frame size, counting the two sync bytes and the two CRC bytes, and a CRC verdict. It then holds that result and ignores further input until the surrounding logic issues a frame clear. A sticky timeout flag reports that no frame start was found within a set number of cycles.

Top module: `nfcf_deframer`

## Requirements
- R1: After reset, out_valid, frame_done, crc_good and rx_timeout are 0 and frame_len is 0.
- R2: Bit 0 of each input byte is the earliest bit in time. Frame bytes are built with their earliest bit as the MSB. The sync pattern 0xB24D is detected when it ends at any of the 8 bit positions of an input byte (offsets 0 to 7). Every later frame byte is reassembled across that offset.
- R3: While hunting with no sync attempt open, zero input bytes are ignored and any nonzero byte opens an attempt. A zero input byte during an open attempt abandons it, so sync bits before the zero byte can never complete a match.
- R4: The first frame byte after sync is the length L. It is followed by L-1 payload bytes and then 2 CRC bytes. Each of these frame bytes appears on out_byte with out_valid high for one cycle, one cycle after the input byte that completes it.
- R5: frame_done pulses for exactly one cycle, one cycle after the input byte that completes the second CRC byte. frame_len then reads L+4.
- R6: crc_good is set with frame_done when CRC-16 (polynomial 0x1021, initial value 0x0000, MSB first) run over the length byte through both CRC bytes leaves 0. The CRC is sent high byte first. crc_good is 0 otherwise.
- R7: After frame_done, input bytes are ignored until frame_clear. No out_valid and no frame_done occur, and frame_len and crc_good keep their values.
- R8: A length byte below 2, or one with L+4 above MAX_FRAME, sends the block back to hunting. It produces no out_valid for that byte and no frame_done. The lengths 2 and MAX_FRAME-4 are accepted.
- R9: rx_timeout rises after TIMEOUT_CYC clock cycles spent hunting since reset or since the last frame_clear. Cycles after an accepted length byte are not counted. The flag stays high until frame_clear.
- R10: frame_clear returns the block to hunting. One cycle later it leaves crc_good, frame_len and rx_timeout at 0 and restarts the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | rx_byte holds a new group of eight received bits |
| rx_byte | input | 8 | Received bits, bit 0 earliest |
| frame_clear | input | 1 | Drop the held frame and start hunting again |
| out_valid | output | 1 | out_byte holds a recovered frame byte |
| out_byte | output | 8 | Recovered frame byte (length, payload, CRC) |
| frame_done | output | 1 | One-cycle pulse when the last CRC byte is taken |
| frame_len | output | $clog2(MAX_FRAME+1) | Total frame size L+4 of the last accepted frame |
| crc_good | output | 1 | CRC residue of the completed frame was zero |
| rx_timeout | output | 1 | Sticky: no frame start within TIMEOUT_CYC hunting cycles |

## Verification
The bench builds the block with MAX_FRAME = 16 and TIMEOUT_CYC = 40. The small frame limit makes the upper length bound reachable with a 13-byte length value, and it lets the largest legal frame (length 12) be tested beside it. The short timeout lets the bench cross the exact expiry cycle and also show that a long stall after an accepted length byte never raises the flag. Frames are sent at every sync bit offset from 0 to 7, with payloads both with and without zero bytes.

// File: rtl/nfcf_pkg.sv
// Shared definitions for the NFC-F deframer: receive states, the sync
// pattern, bit reversal and a single-byte CRC-16 (0x1021) update.
package nfcf_pkg;

    localparam logic [15:0] SYNC_PATTERN = 16'hB24D;
    localparam int          OCTET_W      = 8;

    typedef enum logic [2:0] {
        ST_IDLE,    // hunting, no sync attempt open
        ST_SEEK,    // hunting, sync attempt open
        ST_LEN,     // next frame byte is the length
        ST_BODY,    // collecting payload bytes
        ST_CHECK,   // collecting the two CRC bytes
        ST_HOLD     // frame complete, waiting for clear
    } rx_state_t;

    // Swap bit order so the earliest received bit becomes the MSB.
    function automatic logic [OCTET_W-1:0] bit_reverse(input logic [OCTET_W-1:0] v);
        logic [OCTET_W-1:0] r;
        for (int i = 0; i < OCTET_W; i++) r[i] = v[OCTET_W-1-i];
        return r;
    endfunction

    // Advance a CRC-16 (poly 0x1021) over one byte, MSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

endpackage

// File: rtl/nfcf_sync_hunt.sv
// Sync search over one incoming byte. It tests every bit position at
// which the 16-bit sync pattern can end inside the byte and reports the
// earliest match, together with how many bits of the byte follow the
// sync (the tail). Assumes the window holds the last 15 received bits,
// time ordered with the earliest in the MSB.
module nfcf_sync_hunt
    import nfcf_pkg::*;
(
    input  logic [14:0] win_q,      // previous 15 bits, time ordered
    input  logic [7:0]  bits_in,    // new byte, earliest bit in MSB
    output logic        hit,        // sync ends inside this byte
    output logic [2:0]  tail_bits,  // bits of this byte after the sync
    output logic [14:0] win_next    // window advanced by the full byte
);

    logic [22:0] joined;
    logic [8:1]  match;

    assign joined   = {win_q, bits_in};
    assign win_next = joined[14:0];

    // One comparator per bit count k consumed from the new byte.
    for (genvar k = 1; k <= 8; k++) begin : g_pos
        assign match[k] = (joined[23-k -: 16] == SYNC_PATTERN);
    end

    // Pick the earliest end position; tail is the bits left in the byte.
    always_comb begin
        hit       = 1'b0;
        tail_bits = 3'd0;
        for (int k = 8; k >= 1; k--) begin
            if (match[k]) begin
                hit       = 1'b1;
                tail_bits = 3'(8 - k);
            end
        end
    end

endmodule

// File: rtl/nfcf_realign.sv
// Byte realignment. It keeps the previous input byte and forms a frame
// byte from the last `tail` bits of that byte followed by the leading
// bits of the current byte. Assumes input bytes are already bit reversed
// (earliest bit in MSB) and that tail is stable once sync is found.
module nfcf_realign (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_bits,
    input  logic [2:0] tail,
    output logic [7:0] aligned
);

    logic [7:0]  prev_q;
    logic [15:0] pair;

    // Remember the last accepted byte for the next split.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_q <= '0;
        else if (in_valid) prev_q <= in_bits;
    end

    // Select the eight bits straddling the byte boundary.
    assign pair    = {prev_q, in_bits};
    assign aligned = pair[{1'b0, tail} +: 8];

endmodule

// File: rtl/nfcf_crc_acc.sv
// CRC-16 accumulator over frame bytes. It restarts to zero when a new
// frame is synced and folds in one byte per enable. Assumes restart and
// enable are never high together.
module nfcf_crc_acc
    import nfcf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc_next
);

    logic [15:0] crc_q;

    assign crc_next = crc16_step(crc_q, data);

    // Hold the running remainder between frame bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) crc_q <= '0;
        else if (en)           crc_q <= crc_next;
    end

endmodule

// File: rtl/nfcf_hunt_timer.sv
// Receive timeout counter. It counts cycles while `counting` is high and
// sets a sticky flag after LIMIT such cycles. clear zeroes both.
// Assumes LIMIT >= 1.
module nfcf_hunt_timer #(
    parameter int LIMIT = 4096,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic counting,
    output logic expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count hunting cycles and latch expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (counting && !expired) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(LIMIT - 1)) expired <= 1'b1;
        end
    end

endmodule

// File: rtl/nfcf_deframer.sv
// NFC-F frame receiver. It hunts for the sync pattern at any bit offset,
// realigns later bytes, emits length, payload and CRC bytes, checks the
// CRC and holds the result until frame_clear. Assumes one input byte per
// rx_valid, with bit 0 earliest in time.
module nfcf_deframer
    import nfcf_pkg::*;
#(
    parameter int MAX_FRAME   = 260,
    parameter int TIMEOUT_CYC = 4096,
    localparam int LEN_W      = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             frame_clear,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             frame_done,
    output logic [LEN_W-1:0] frame_len,
    output logic             crc_good,
    output logic             rx_timeout
);

    rx_state_t   state_q;
    logic [14:0] win_q;
    logic [2:0]  tail_q;
    logic [7:0]  rem_q;
    logic        crc_idx_q;

    logic [7:0]  rev_byte;
    logic        hunt_hit;
    logic [2:0]  hunt_tail;
    logic [14:0] win_next;
    logic [7:0]  aligned;
    logic [15:0] crc_next;
    logic        len_ok;
    logic        take;
    logic        crc_restart;
    logic        crc_en;

    assign rev_byte = bit_reverse(rx_byte);
    assign take     = rx_valid && !frame_clear;

    nfcf_sync_hunt u_hunt (
        .win_q     (win_q),
        .bits_in   (rev_byte),
        .hit       (hunt_hit),
        .tail_bits (hunt_tail),
        .win_next  (win_next)
    );

    nfcf_realign u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_bits  (rev_byte),
        .tail     (tail_q),
        .aligned  (aligned)
    );

    nfcf_crc_acc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (crc_restart),
        .en       (crc_en),
        .data     (aligned),
        .crc_next (crc_next)
    );

    nfcf_hunt_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_clear),
        .counting (state_q == ST_IDLE || state_q == ST_SEEK),
        .expired  (rx_timeout)
    );

    // Length window check: at least 2, total size within MAX_FRAME.
    assign len_ok = (aligned >= 8'd2) &&
                    ((10'(aligned) + 10'd4) <= 10'(MAX_FRAME));

    // CRC restarts at sync and absorbs every emitted frame byte.
    assign crc_restart = take && (state_q == ST_SEEK) && hunt_hit;
    assign crc_en      = take && (((state_q == ST_LEN) && len_ok) ||
                                  (state_q == ST_BODY) || (state_q == ST_CHECK));

    // Receive state machine and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            win_q      <= '0;
            tail_q     <= '0;
            rem_q      <= '0;
            crc_idx_q  <= 1'b0;
            out_valid  <= 1'b0;
            out_byte   <= '0;
            frame_done <= 1'b0;
            frame_len  <= '0;
            crc_good   <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            frame_done <= 1'b0;
            if (frame_clear) begin
                state_q  <= ST_IDLE;
                win_q    <= '0;
                frame_len <= '0;
                crc_good <= 1'b0;
            end else if (rx_valid) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (rx_byte != 8'h00) begin
                            win_q   <= {7'd0, rev_byte};
                            state_q <= ST_SEEK;
                        end
                    end
                    ST_SEEK: begin
                        if (rx_byte == 8'h00) begin
                            state_q <= ST_IDLE;
                        end else if (hunt_hit) begin
                            tail_q  <= hunt_tail;
                            state_q <= ST_LEN;
                        end else begin
                            win_q <= win_next;
                        end
                    end
                    ST_LEN: begin
                        if (len_ok) begin
                            out_valid <= 1'b1;
                            out_byte  <= aligned;
                            frame_len <= LEN_W'(10'(aligned) + 10'd4);
                            rem_q     <= aligned - 8'd1;
                            state_q   <= ST_BODY;
                        end else begin
                            win_q   <= '0;
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_BODY: begin
                        out_valid <= 1'b1;
                        out_byte  <= aligned;
                        rem_q     <= rem_q - 8'd1;
                        crc_idx_q <= 1'b0;
                        if (rem_q == 8'd1) state_q <= ST_CHECK;
                    end
                    ST_CHECK: begin
                        out_valid <= 1'b1;
                        out_byte  <= aligned;
                        if (crc_idx_q) begin
                            frame_done <= 1'b1;
                            crc_good   <= (crc_next == 16'h0000);
                            state_q    <= ST_HOLD;
                        end else begin
                            crc_idx_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/nfcf_deframer_chk.sv
// Port-level property checker for nfcf_deframer, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module nfcf_deframer_chk #(
    parameter int MAX_FRAME = 260,
    parameter int LEN_W     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             frame_clear,
    input logic             out_valid,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len,
    input logic             crc_good,
    input logic             rx_timeout
);

    // R4: an output byte only follows an accepted input byte.
    assert_out_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(rx_valid) && !$past(frame_clear)));

    // R5: completion is a single-cycle pulse.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8: a completed frame always has a legal total size.
    assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ((frame_len >= LEN_W'(6)) && (frame_len <= LEN_W'(MAX_FRAME))));

    // R6: the CRC verdict only rises together with completion.
    assert_good_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_good) |-> frame_done);

    // R9: the timeout flag is sticky until a clear.
    assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && !frame_clear) |=> rx_timeout);

    // R10: a clear leaves the result and the flag low.
    assert_clear_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clear |=> (!crc_good && !rx_timeout && !frame_done && !out_valid));

endmodule

bind nfcf_deframer nfcf_deframer_chk #(
    .MAX_FRAME (MAX_FRAME),
    .LEN_W     (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .frame_clear (frame_clear),
    .out_valid   (out_valid),
    .frame_done  (frame_done),
    .frame_len   (frame_len),
    .crc_good    (crc_good),
    .rx_timeout  (rx_timeout)
);

// File: tb/nfcf_deframer_bench.sv
`timescale 1ns/1ps
// Directed bench for nfcf_deframer: one task per scenario.
module nfcf_deframer_bench;

    localparam int MAXF = 16;
    localparam int TOUT = 40;
    localparam int LW   = $clog2(MAXF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          frame_clear = 1'b0;
    logic          out_valid;
    logic [7:0]    out_byte;
    logic          frame_done;
    logic [LW-1:0] frame_len;
    logic          crc_good;
    logic          rx_timeout;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] cap [0:511];
    int   cap_n = 0;
    int   done_n = 0;
    int   pulse_err = 0;
    bit   done_prev = 1'b0;

    logic [7:0] fb [0:31];
    bit         bits [0:639];

    always #10 clk = ~clk;

    nfcf_deframer #(.MAX_FRAME(MAXF), .TIMEOUT_CYC(TOUT)) u_nfcf_deframer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frame_clear(frame_clear), .out_valid(out_valid), .out_byte(out_byte),
        .frame_done(frame_done), .frame_len(frame_len), .crc_good(crc_good),
        .rx_timeout(rx_timeout));

    // Output monitor, sampling between clock edges.
    always @(negedge clk) begin
        if (out_valid) begin
            cap[cap_n % 512] = out_byte;
            cap_n++;
        end
        if (frame_done) begin
            done_n++;
            if (done_prev) pulse_err++;
        end
        done_prev = frame_done;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference CRC-16, poly 0x1021, init 0, MSB first.
    function automatic logic [15:0] ref_crc(input int first, input int last);
        logic [15:0] c = 16'h0000;
        for (int j = first; j <= last; j++) begin
            c = c ^ {fb[j], 8'h00};
            for (int b = 0; b < 8; b++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    // Fill fb with sync, length, payload and CRC; returns byte count.
    function automatic int build_frame(input int len, input bit corrupt, input bit zeros, input int seed);
        logic [15:0] c;
        fb[0] = 8'hB2;
        fb[1] = 8'h4D;
        fb[2] = len[7:0];
        for (int i = 0; i < len - 1; i++)
            fb[3+i] = (zeros && (i % 2 == 0)) ? 8'h00 : 8'((seed * 37 + i * 29 + 3) & 255);
        c = ref_crc(2, len + 1);
        fb[len+2] = c[15:8];
        fb[len+3] = c[7:0] ^ (corrupt ? 8'h01 : 8'h00);
        return len + 4;
    endfunction

    // Serialize fb[0..nfb-1] after off zero bits; bit 0 of each input byte first.
    task automatic send_stream(input int off, input int nfb, input int gap_at);
        int nb = 0;
        for (int i = 0; i < off; i++) bits[nb++] = 1'b0;
        for (int j = 0; j < nfb; j++)
            for (int b = 7; b >= 0; b--) bits[nb++] = fb[j][b];
        while (nb % 8 != 0) bits[nb++] = 1'b0;
        for (int k = 0; k < nb / 8; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            for (int i = 0; i < 8; i++) rx_byte[i] = bits[8*k+i];
            if (k == gap_at) begin
                @(negedge clk);
                rx_valid = 1'b0;
                repeat (60) @(negedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic pulse_clear;
        @(negedge clk);
        frame_clear = 1'b1;
        @(negedge clk);
        frame_clear = 1'b0;
    endtask

    task automatic t_reset;
        check(!out_valid && !frame_done && !crc_good && !rx_timeout && frame_len == 0,
              "R1 reset outputs", {out_valid, frame_done, crc_good, rx_timeout}, 0);
    endtask

    // Full frame at a given bit offset; checks bytes, size, pulse and CRC.
    task automatic t_frame(input int off, input int len, input bit corrupt, input bit zeros,
                           input int gap_at, input bit do_clear);
        int nfb, base, dbase, miss, first_bad;
        nfb   = build_frame(len, corrupt, zeros, off + len);
        base  = cap_n;
        dbase = done_n;
        send_stream(off, nfb, gap_at);
        repeat (3) @(negedge clk);
        check(cap_n - base == len + 2, "R4 emitted byte count", cap_n - base, len + 2);
        miss = 0; first_bad = 0;
        for (int i = 0; i < len + 2; i++)
            if (cap[(base + i) % 512] !== fb[2+i]) begin
                if (miss == 0) first_bad = i;
                miss++;
            end
        check(miss == 0, $sformatf("R2 realigned bytes off=%0d idx=%0d", off, first_bad),
              cap[(base + first_bad) % 512], fb[2+first_bad]);
        check(done_n - dbase == 1, "R5 frame_done count", done_n - dbase, 1);
        check(frame_len == LW'(len + 4), "R5 frame_len", frame_len, len + 4);
        check(crc_good == !corrupt, "R6 crc_good", crc_good, !corrupt);
        if (do_clear) pulse_clear();
    endtask

    // A second frame while a result is held must be ignored.
    task automatic t_hold;
        int base, dbase, nfb;
        t_frame(2, 4, 1'b0, 1'b0, -1, 1'b0);
        nfb   = build_frame(3, 1'b0, 1'b0, 9);
        base  = cap_n;
        dbase = done_n;
        send_stream(4, nfb, -1);
        repeat (3) @(negedge clk);
        check(cap_n == base, "R7 no bytes while held", cap_n - base, 0);
        check(done_n == dbase, "R7 no completion while held", done_n - dbase, 0);
        check(frame_len == LW'(8), "R7 frame_len kept", frame_len, 8);
        check(crc_good == 1'b1, "R7 crc_good kept", crc_good, 1);
        pulse_clear();
        check(!crc_good && frame_len == 0 && !rx_timeout, "R10 clear zeroes result",
              {crc_good, rx_timeout}, 0);
    endtask

    // Zero byte inside an open sync attempt must break it.
    task automatic t_zero_abort;
        int base, dbase;
        logic [7:0] seq [0:7];
        seq = '{8'h4D, 8'h00, 8'hB2, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44};
        base  = cap_n;
        dbase = done_n;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = seq[k];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
        repeat (3) @(negedge clk);
        check(cap_n == base, "R3 split sync rejected", cap_n - base, 0);
        check(done_n == dbase, "R3 no completion", done_n - dbase, 0);
        pulse_clear();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = 8'h00;
        end
        t_frame(6, 3, 1'b0, 1'b0, -1, 1'b1);
    endtask

    // Illegal length values return to hunting; the next frame still decodes.
    task automatic t_badlen(input int len);
        int base, dbase;
        fb[0] = 8'hB2; fb[1] = 8'h4D; fb[2] = len[7:0];
        fb[3] = 8'h00; fb[4] = 8'h00;
        base  = cap_n;
        dbase = done_n;
        send_stream(3, 5, -1);
        repeat (3) @(negedge clk);
        check(cap_n == base, $sformatf("R8 length %0d rejected", len), cap_n - base, 0);
        check(done_n == dbase, "R8 no completion", done_n - dbase, 0);
        t_frame(1, 2, 1'b0, 1'b0, -1, 1'b1);
    endtask

    // Timeout expires on the exact cycle, then clears.
    task automatic t_timeout;
        pulse_clear();
        repeat (TOUT - 1) @(negedge clk);
        check(rx_timeout == 1'b0, "R9 not yet expired", rx_timeout, 0);
        @(negedge clk);
        check(rx_timeout == 1'b1, "R9 expired", rx_timeout, 1);
        repeat (5) @(negedge clk);
        check(rx_timeout == 1'b1, "R9 sticky", rx_timeout, 1);
        pulse_clear();
        check(rx_timeout == 1'b0, "R10 clear drops timeout", rx_timeout, 0);
    endtask

    // Long stall after the length byte must not raise the timeout.
    task automatic t_no_timeout_after_len;
        pulse_clear();
        t_frame(0, MAXF - 4, 1'b0, 1'b0, 2, 1'b0);
        check(rx_timeout == 1'b0, "R9 stall after length not counted", rx_timeout, 0);
        pulse_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(0, 5, 1'b0, 1'b0, -1, 1'b1);
        t_frame(3, 6, 1'b0, 1'b1, -1, 1'b1);
        t_frame(7, 9, 1'b1, 1'b0, -1, 1'b1);
        foreach (bits[i]) bits[i] = 1'b0;
        for (int off = 1; off < 7; off++) t_frame(off, 2, 1'b0, 1'b0, -1, 1'b1);
        t_hold();
        t_zero_abort();
        t_badlen(1);
        t_badlen(MAXF - 3);
        t_timeout();
        t_no_timeout_after_len();
        check(pulse_err == 0, "R5 completion pulse width", pulse_err, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule